// File: doc/BRIEF.md
# Boundary-Scan Instruction Decoder and Data Register Selector

This block sits next to a test access port state machine and the instruction shift register. It receives a new instruction on the update-instruction strobe and holds it as the active instruction. It also receives the data-register strobes for capture, shift and update. From the active instruction it chooses which test data register sits between the serial data input and the serial data output. It also sets what the boundary cells do to the output pins and whether the core logic is held.

The block contains two test data registers. The first is a one-stage bypass register. The second is a 32-bit identification register. That register captures either a fixed identity word built from parameters or a code supplied on an input port. The boundary register is outside the block. The block reaches it only through a select line, gated capture, shift and update strobes, and the boundary chain's serial output.

Top module: `scan_instr_decode`

## Requirements
- R1: After `trst_n` is asserted low, the active instruction is IDCODE (code 4'b0010). Both pin-control outputs are 0, which is normal functional mode. `core_hold`, `in_from_bsr` and `bist_en` are 0.
- R2: Opcode assignments are EXTEST=0, SAMPLE/PRELOAD=1, IDCODE=2, USERCODE=3, INTEST=4, RUNBIST=5, CLAMP=6, HIGHZ=7 and BYPASS=15 (all ones).
- R3: When the bypass register is selected, a capture loads 0 into it. Each shift then moves `tdi` to `tdo` with a delay of exactly one stage.
- R4: With IDCODE active, a capture loads the word {VERSION[3:0], PART[15:0], MFR[10:0], 1'b1}: version in bits 31:28, part number in bits 27:12, manufacturer in bits 11:1 and a 1 in bit 0. Shifts present that word on `tdo` least significant bit first, with `tdi` entering at bit 31.
- R5: With USERCODE active, the identification register is also selected, but a capture loads `user_code` instead of the fixed word.
- R6: EXTEST, SAMPLE/PRELOAD, INTEST and RUNBIST select the boundary register. In that case `bsr_select` is 1 and `tdo` equals `bsr_so`. `bsr_capture`, `bsr_shift` and `bsr_update` repeat the data-register strobes only while the boundary register is selected and are 0 otherwise.
- R7: `pin_from_bsr` is 1 for EXTEST, INTEST, CLAMP and for RUNBIST when RUNBIST_FLOAT=0. `pin_hiz` is 1 only for HIGHZ and for RUNBIST when RUNBIST_FLOAT=1. The two outputs are never both 1.
- R8: With HIGHZ active, `pin_hiz` is 1 and the serial path goes through the bypass register.
- R9: With CLAMP active, `pin_from_bsr` is 1 and the serial path goes through the bypass register.
- R10: `core_hold` is 1 exactly for EXTEST, CLAMP and HIGHZ. `in_from_bsr` is 1 exactly for INTEST. `bist_en` is 1 exactly for RUNBIST.
- R11: Every unassigned code (8 to 14) behaves like BYPASS: the bypass path is selected, pins stay functional and `core_hold` is 0.
- R12: The active instruction changes only on a clock edge where `update_ir` is 1. Register selection and `tdo` follow the active instruction, not the value on `instr_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| update_ir | input | 1 | Update-instruction strobe from the state machine |
| instr_in | input | 4 | Parallel value of the instruction shift register |
| capture_dr | input | 1 | Capture-data-register strobe |
| shift_dr | input | 1 | Shift-data-register strobe |
| update_dr | input | 1 | Update-data-register strobe |
| tdi | input | 1 | Serial test data input |
| user_code | input | 32 | User-programmed identification code |
| bsr_so | input | 1 | Serial output of the external boundary register |
| tdo | output | 1 | Serial test data output (selected register) |
| active_op | output | 4 | Active (latched) instruction |
| bsr_select | output | 1 | Boundary register is in the serial path |
| bsr_capture | output | 1 | Gated capture strobe to the boundary register |
| bsr_shift | output | 1 | Gated shift strobe to the boundary register |
| bsr_update | output | 1 | Gated update strobe to the boundary register |
| pin_from_bsr | output | 1 | Output pins driven from boundary cells |
| pin_hiz | output | 1 | Output pins forced to high impedance |
| in_from_bsr | output | 1 | Core inputs fed from boundary cells |
| core_hold | output | 1 | Core logic held |
| bist_en | output | 1 | Self-test run enabled |

## Verification
A wrongly latched active instruction shows on the pin-control, hold and select outputs on the negative edge that follows the update strobe, one clock after the load. A fault in the identification register shows within 32 shift cycles of a capture. A flipped bit appears on `tdo` in the cycle whose index equals its bit position. A bypass register that does not clear shows on the very first shifted bit. A wrong path selection shows at once, because `tdo` then stops tracking either `bsr_so` or the delayed `tdi`.

// File: rtl/sid_pkg.sv
package sid_pkg;
  localparam int OP_W = 4;
  localparam int ID_W = 32;

  localparam logic [OP_W-1:0] OP_EXTEST   = 4'h0;
  localparam logic [OP_W-1:0] OP_SAMPLE   = 4'h1;
  localparam logic [OP_W-1:0] OP_IDCODE   = 4'h2;
  localparam logic [OP_W-1:0] OP_USERCODE = 4'h3;
  localparam logic [OP_W-1:0] OP_INTEST   = 4'h4;
  localparam logic [OP_W-1:0] OP_RUNBIST  = 4'h5;
  localparam logic [OP_W-1:0] OP_CLAMP    = 4'h6;
  localparam logic [OP_W-1:0] OP_HIGHZ    = 4'h7;
  localparam logic [OP_W-1:0] OP_BYPASS   = 4'hF;

  typedef enum logic [1:0] {PATH_BYP = 2'd0, PATH_ID = 2'd1, PATH_BSR = 2'd2} path_e;

  typedef struct packed {
    path_e path;
    logic  id_user;
    logic  pin_bsr;
    logic  pin_hiz;
    logic  core_hold;
    logic  in_bsr;
    logic  bist_en;
  } ctl_t;

  // Per-instruction control word; unassigned codes fall back to bypass.
  function automatic ctl_t decode_op(logic [OP_W-1:0] op, logic runbist_float);
    ctl_t c;
    c = '{path: PATH_BYP, id_user: 1'b0, pin_bsr: 1'b0, pin_hiz: 1'b0,
          core_hold: 1'b0, in_bsr: 1'b0, bist_en: 1'b0};
    case (op)
      OP_EXTEST:   begin c.path = PATH_BSR; c.pin_bsr = 1'b1; c.core_hold = 1'b1; end
      OP_SAMPLE:   c.path = PATH_BSR;
      OP_IDCODE:   c.path = PATH_ID;
      OP_USERCODE: begin c.path = PATH_ID; c.id_user = 1'b1; end
      OP_INTEST:   begin c.path = PATH_BSR; c.pin_bsr = 1'b1; c.in_bsr = 1'b1; end
      OP_RUNBIST:  begin
        c.path    = PATH_BSR;
        c.bist_en = 1'b1;
        c.pin_hiz = runbist_float;
        c.pin_bsr = ~runbist_float;
      end
      OP_CLAMP:    begin c.pin_bsr = 1'b1; c.core_hold = 1'b1; end
      OP_HIGHZ:    begin c.pin_hiz = 1'b1; c.core_hold = 1'b1; end
      default:     ;
    endcase
    return c;
  endfunction

  // Fixed identity word: version | part | manufacturer | marker bit.
  function automatic logic [ID_W-1:0] make_id(logic [3:0] ver, logic [15:0] part,
                                              logic [10:0] mfr);
    return {ver, part, mfr, 1'b1};
  endfunction
endpackage

// File: rtl/sid_instr_latch.sv
module sid_instr_latch
  import sid_pkg::*;
#(
  parameter bit RUNBIST_FLOAT = 1'b0
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            update_ir,
  input  logic [OP_W-1:0] instr_in,
  output logic [OP_W-1:0] active_op,
  output ctl_t            ctl
);
  logic [OP_W-1:0] op_q;
  logic            ev_load;

  assign ev_load = update_ir;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      op_q <= OP_IDCODE;
    else if (ev_load) op_q <= instr_in;
  end

  assign active_op = op_q;
  assign ctl       = decode_op(op_q, RUNBIST_FLOAT);

  // R12: instruction held between update strobes
  p_hold_instr_r12: assert property (@(posedge tck) disable iff (!trst_n)
    !ev_load |=> $stable(op_q));
  // R12: a load takes the presented code
  p_load_instr_r12: assert property (@(posedge tck) disable iff (!trst_n)
    ev_load |=> op_q == $past(instr_in));
endmodule

// File: rtl/sid_bypass.sv
module sid_bypass (
  input  logic tck,
  input  logic trst_n,
  input  logic cap,
  input  logic shf,
  input  logic tdi,
  output logic q
);
  logic stage_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  stage_q <= 1'b0;
    else if (cap) stage_q <= 1'b0;
    else if (shf) stage_q <= tdi;
  end

  assign q = stage_q;

  // R3: capture clears the stage
  p_cap_zero_r3: assert property (@(posedge tck) disable iff (!trst_n)
    cap |=> !q);
  // R3: one-stage delay while shifting
  p_one_stage_r3: assert property (@(posedge tck) disable iff (!trst_n)
    (shf && !cap) |=> q == $past(tdi));
endmodule

// File: rtl/sid_ident.sv
module sid_ident
  import sid_pkg::*;
#(
  parameter logic [3:0]  VERSION = 4'h3,
  parameter logic [15:0] PART    = 16'hA5C1,
  parameter logic [10:0] MFR     = 11'h2B5
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            cap,
  input  logic            shf,
  input  logic            use_user,
  input  logic [ID_W-1:0] user_code,
  input  logic            tdi,
  output logic            so
);
  localparam logic [ID_W-1:0] FIXED_ID = make_id(VERSION, PART, MFR);

  logic [ID_W-1:0] id_q;
  logic [ID_W-1:0] cap_word;
  logic            ev_cap_fixed;

  assign cap_word     = use_user ? user_code : FIXED_ID;
  assign ev_cap_fixed = cap && !use_user;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)  id_q <= '0;
    else if (cap) id_q <= cap_word;
    else if (shf) id_q <= {tdi, id_q[ID_W-1:1]};
  end

  assign so = id_q[0];

  // R4: the fixed word always presents the marker bit first
  p_marker_r4: assert property (@(posedge tck) disable iff (!trst_n)
    ev_cap_fixed |=> so);
  // R4: serial input enters at the top bit
  p_shift_in_r4: assert property (@(posedge tck) disable iff (!trst_n)
    (shf && !cap) |=> id_q[ID_W-1] == $past(tdi));
  // R5: user capture takes the port value
  p_user_cap_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (cap && use_user) |=> id_q == $past(user_code));
endmodule

// File: rtl/scan_instr_decode.sv
module scan_instr_decode
  import sid_pkg::*;
#(
  parameter logic [3:0]  VERSION       = 4'h3,
  parameter logic [15:0] PART          = 16'hA5C1,
  parameter logic [10:0] MFR           = 11'h2B5,
  parameter bit          RUNBIST_FLOAT = 1'b0
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        update_ir,
  input  logic [3:0]  instr_in,
  input  logic        capture_dr,
  input  logic        shift_dr,
  input  logic        update_dr,
  input  logic        tdi,
  input  logic [31:0] user_code,
  input  logic        bsr_so,
  output logic        tdo,
  output logic [3:0]  active_op,
  output logic        bsr_select,
  output logic        bsr_capture,
  output logic        bsr_shift,
  output logic        bsr_update,
  output logic        pin_from_bsr,
  output logic        pin_hiz,
  output logic        in_from_bsr,
  output logic        core_hold,
  output logic        bist_en
);
  ctl_t ctl;
  logic sel_byp, sel_id, sel_bsr;
  logic byp_q, id_so;

  sid_instr_latch #(.RUNBIST_FLOAT(RUNBIST_FLOAT)) u_latch (
    .tck(tck), .trst_n(trst_n), .update_ir(update_ir), .instr_in(instr_in),
    .active_op(active_op), .ctl(ctl)
  );

  assign sel_byp = (ctl.path == PATH_BYP);
  assign sel_id  = (ctl.path == PATH_ID);
  assign sel_bsr = (ctl.path == PATH_BSR);

  sid_bypass u_byp (
    .tck(tck), .trst_n(trst_n), .cap(capture_dr && sel_byp),
    .shf(shift_dr && sel_byp), .tdi(tdi), .q(byp_q)
  );

  sid_ident #(.VERSION(VERSION), .PART(PART), .MFR(MFR)) u_id (
    .tck(tck), .trst_n(trst_n), .cap(capture_dr && sel_id),
    .shf(shift_dr && sel_id), .use_user(ctl.id_user), .user_code(user_code),
    .tdi(tdi), .so(id_so)
  );

  always_comb begin
    unique case (ctl.path)
      PATH_ID:  tdo = id_so;
      PATH_BSR: tdo = bsr_so;
      default:  tdo = byp_q;
    endcase
  end

  assign bsr_select   = sel_bsr;
  assign bsr_capture  = capture_dr && sel_bsr;
  assign bsr_shift    = shift_dr   && sel_bsr;
  assign bsr_update   = update_dr  && sel_bsr;
  assign pin_from_bsr = ctl.pin_bsr;
  assign pin_hiz      = ctl.pin_hiz;
  assign in_from_bsr  = ctl.in_bsr;
  assign core_hold    = ctl.core_hold;
  assign bist_en      = ctl.bist_en;

  // R7: pin drive modes are exclusive
  p_pin_excl_r7: assert property (@(posedge tck) disable iff (!trst_n)
    !(pin_hiz && pin_from_bsr));
  // R6: boundary strobes only reach a selected chain
  p_bsr_gate_r6: assert property (@(posedge tck) disable iff (!trst_n)
    (bsr_capture || bsr_shift || bsr_update) |-> bsr_select);
  // R6: serial output follows the boundary chain when selected
  p_bsr_tdo_r6: assert property (@(posedge tck) disable iff (!trst_n)
    bsr_select |-> tdo == bsr_so);
  // R8: high-impedance instruction floats pins and uses the bypass path
  p_highz_r8: assert property (@(posedge tck) disable iff (!trst_n)
    (active_op == OP_HIGHZ) |-> (pin_hiz && !bsr_select && tdo == byp_q));
  // R9: clamp drives from boundary cells over the bypass path
  p_clamp_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (active_op == OP_CLAMP) |-> (pin_from_bsr && !bsr_select && tdo == byp_q));
endmodule

// File: tb/test_scan_instr_decode.sv
`timescale 1ns/1ps
module test_scan_instr_decode;
  localparam logic [3:0]  VER  = 4'h3;
  localparam logic [15:0] PRT  = 16'hA5C1;
  localparam logic [10:0] MAN  = 11'h2B5;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic update_ir = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0, bsr_so = 0;
  logic [3:0]  instr_in = 4'h0;
  logic [31:0] user_code = 32'h0;
  logic tdo, bsr_select, bsr_capture, bsr_shift, bsr_update;
  logic pin_from_bsr, pin_hiz, in_from_bsr, core_hold, bist_en;
  logic [3:0] active_op;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2.5 tck = ~tck;

  scan_instr_decode i_scan_instr_decode (
    .tck(tck), .trst_n(trst_n), .update_ir(update_ir), .instr_in(instr_in),
    .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
    .tdi(tdi), .user_code(user_code), .bsr_so(bsr_so), .tdo(tdo),
    .active_op(active_op), .bsr_select(bsr_select), .bsr_capture(bsr_capture),
    .bsr_shift(bsr_shift), .bsr_update(bsr_update), .pin_from_bsr(pin_from_bsr),
    .pin_hiz(pin_hiz), .in_from_bsr(in_from_bsr), .core_hold(core_hold),
    .bist_en(bist_en)
  );

  // Bench-side expectations, written from the requirement tables.
  function automatic logic [31:0] ref_id();
    logic [31:0] w;
    w = 32'd1;
    w = w | (32'(MAN) << 1);
    w = w | (32'(PRT) << 12);
    w = w | (32'(VER) << 28);
    return w;
  endfunction
  function automatic int ref_path(logic [3:0] op); // 0 bypass, 1 id, 2 boundary
    if (op == 4'd0 || op == 4'd1 || op == 4'd4 || op == 4'd5) return 2;
    if (op == 4'd2 || op == 4'd3) return 1;
    return 0;
  endfunction
  function automatic logic ref_pbsr(logic [3:0] op);
    return (op == 4'd0) || (op == 4'd4) || (op == 4'd5) || (op == 4'd6);
  endfunction
  function automatic logic ref_hiz(logic [3:0] op);
    return op == 4'd7;
  endfunction
  function automatic logic ref_hold(logic [3:0] op);
    return (op == 4'd0) || (op == 4'd6) || (op == 4'd7);
  endfunction

  task automatic check(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_op(input logic [3:0] op);
    @(negedge tck);
    instr_in = op; update_ir = 1'b1;
    @(negedge tck);
    update_ir = 1'b0;
    #1;
  endtask

  task automatic check_ctl(input logic [3:0] op);
    check(active_op == op, "R2 active", 32'(active_op), 32'(op));
    check(bsr_select == (ref_path(op) == 2), "R6 select", 32'(bsr_select),
          32'(ref_path(op) == 2));
    check(pin_from_bsr == ref_pbsr(op), "R7 pin_from_bsr", 32'(pin_from_bsr),
          32'(ref_pbsr(op)));
    check(pin_hiz == ref_hiz(op), "R7 pin_hiz", 32'(pin_hiz), 32'(ref_hiz(op)));
    check(core_hold == ref_hold(op), "R10 core_hold", 32'(core_hold), 32'(ref_hold(op)));
    check(in_from_bsr == (op == 4'd4), "R10 in_from_bsr", 32'(in_from_bsr), 32'(op == 4'd4));
    check(bist_en == (op == 4'd5), "R10 bist_en", 32'(bist_en), 32'(op == 4'd5));
  endtask

  // Capture then shift n bits, checking tdo per the selected path.
  task automatic cap_shift(input logic [3:0] op, input int n);
    logic [31:0] word;
    logic prev;
    int path;
    path = ref_path(op);
    word = (op == 4'd3) ? user_code : ref_id();
    @(negedge tck);
    capture_dr = 1'b1;
    #1;
    check(bsr_capture == (path == 2), "R6 capture gate", 32'(bsr_capture), 32'(path == 2));
    @(negedge tck);
    capture_dr = 1'b0;
    prev = 1'b0;
    for (int i = 0; i < n; i++) begin
      shift_dr = 1'b1; tdi = 1'($urandom); bsr_so = 1'($urandom);
      #1;
      check(bsr_shift == (path == 2), "R6 shift gate", 32'(bsr_shift), 32'(path == 2));
      if (path == 2)
        check(tdo == bsr_so, "R6 tdo boundary", 32'(tdo), 32'(bsr_so));
      else if (path == 1)
        check(tdo == word[i], (op == 4'd3) ? "R5 user shift" : "R4 id shift",
              32'(tdo), 32'(word[i]));
      else
        check(tdo == ((i == 0) ? 1'b0 : prev), "R3 bypass R11", 32'(tdo),
              32'((i == 0) ? 1'b0 : prev));
      prev = tdi;
      @(negedge tck);
    end
    shift_dr = 1'b0;
    update_dr = 1'b1;
    #1;
    check(bsr_update == (path == 2), "R6 update gate", 32'(bsr_update), 32'(path == 2));
    @(negedge tck);
    update_dr = 1'b0;
  endtask

  initial begin
    #(5 * 150000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge tck);
    trst_n = 1'b1;
    #1;
    // R1: reset state
    check(active_op == 4'd2, "R1 reset op", 32'(active_op), 32'd2);
    check(!pin_from_bsr && !pin_hiz, "R1 pins functional", 32'({pin_from_bsr, pin_hiz}), 32'd0);
    check(!core_hold && !in_from_bsr && !bist_en, "R1 core", 32'(core_hold), 32'd0);
    cap_shift(4'd2, 32);

    // R12: instr_in alone changes nothing
    @(negedge tck);
    instr_in = 4'hF;
    repeat (2) @(negedge tck);
    #1;
    check(active_op == 4'd2, "R12 no update", 32'(active_op), 32'd2);
    cap_shift(4'd2, 32);

    // Directed: every assigned code plus unassigned corners
    for (int k = 0; k < 16; k++) begin
      user_code = $urandom;
      load_op(4'(k));
      check_ctl(4'(k));
      cap_shift(4'(k), (ref_path(4'(k)) == 1) ? 32 : 6);
    end

    // R8 R9: bypass path under HIGHZ and CLAMP, longer runs
    load_op(4'd7); cap_shift(4'd7, 12);
    load_op(4'd6); cap_shift(4'd6, 12);

    // Random mix
    for (int r = 0; r < 60; r++) begin
      logic [3:0] op;
      op = 4'($urandom);
      user_code = $urandom;
      load_op(op);
      check_ctl(op);
      cap_shift(op, (ref_path(op) == 1) ? 32 : 1 + ($urandom % 10));
    end

    // R1: asynchronous reset back to IDCODE
    load_op(4'd7);
    @(negedge tck);
    trst_n = 1'b0;
    #1;
    check(active_op == 4'd2 && !pin_hiz && !core_hold, "R1 async reset",
          32'(active_op), 32'd2);
    @(negedge tck);
    trst_n = 1'b1;

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule